// File: doc/BRIEF.md
# CCD Horizontal Clock Blanking Generator

This block drives the pair of complementary horizontal transfer clocks of a CCD sensor, `h1` and `h2`, at pixel rate. When the line-sync input `hd` goes low, the block freezes both clocks for the horizontal blanking interval. The frozen level comes from a polarity control. Pulse mode places two one-clock H1 pulses at programmable offsets inside the interval. Extension mode first holds the clocks through a programmable number of extra pixel clocks. During that stretch it raises a suspend strobe, which the downstream line and pixel counters use to stop.

The interval starts on the first clock edge at which `hd` is sampled low while the block is idle. At that same edge the block captures every control field. Changes made later have no effect until the next interval starts. An optional retime stage adds one register to the H1 gating path, on both entry and exit. The blanking flag `hblk` is active low: it is low while blanking or extension is in progress. It returns high on the edge at which `hd` is sampled high.

Top module: `hblk_gen`

## Requirements
- R1: `h2` is the inverse of `h1` in every cycle, including reset and blanking.
- R2: While `rst` is high, `h1` follows `mask_pol`, `suspend` is 0 and `hblk` is 1, even if an interval was in progress.
- R3: From idle, the edge that samples `hd` low drives `hblk` low. Without extension, `hblk` rises on the first edge that samples `hd` high.
- R4: With `pulse_en` = 0, `h1` holds at `mask_pol` (0 low, 1 high) for the whole blanked span, and `pulse_pos` has no effect.
- R5: With `pulse_en` = 1, blanking offsets count from 0 at the first blanked clock after any extension. `h1` takes the inverse of the mask level for exactly one clock at offset `pulse_pos[4:0]` and at offset `pulse_pos[9:5]`. It holds the mask level at all other offsets.
- R6: With `ext_en` = 1 and `ext_len` = N > 0, `suspend` is high for exactly N clocks, starting at the start edge. During those clocks `hblk` is low and `h1` holds the mask level. Offset 0 falls on the clock after them.
- R7: `ext_len` = 0 with `ext_en` = 1 gives the same outputs as `ext_en` = 0.
- R8: With `retime_en` = 1, H1 gating and its level lag the unretimed timing by exactly one clock at both entry and exit. `hblk` and `suspend` are unchanged.
- R9: `mask_pol`, `pulse_en`, `ext_en`, `ext_len`, `retime_en` and `pulse_pos` are captured only when an interval starts. Changing them during an interval does not alter it.
- R10: Outside the gated span, `h1` toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hd | input | 1 | Line-sync level; low requests blanking |
| mask_pol | input | 1 | H1 level during blanking (0 low, 1 high) |
| pulse_en | input | 1 | Enables the two H1 pulses inside blanking |
| ext_en | input | 1 | Enables extended blanking |
| retime_en | input | 1 | Adds a retiming register on the H1 gate |
| pulse_pos | input | 10 | Two 5-bit pulse offsets, low half first pulse |
| ext_len | input | 9 | Extension length in pixel clocks |
| h1 | output | 1 | Horizontal clock phase 1 |
| h2 | output | 1 | Horizontal clock phase 2, inverse of h1 |
| hblk | output | 1 | Blanking flag, low while blanking |
| suspend | output | 1 | Stall strobe for line and pixel counters |

## Verification
The hardest case to reach from the ports combines retime, extension and pulses in one interval. The pulse offsets then depend both on the extension length and on the extra retime delay, and offset 0 lands in the clock just after suspend drops. The stimulus table includes an interval with all three enabled and pulses at offsets 0 and 1, so any off-by-one at the extension boundary shows up on `h1`. A separate directed test changes every control in the middle of an interval. It checks that the running interval keeps its captured values and that the next interval picks up the new ones.

// File: rtl/hblk_pkg.sv
package hblk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXT   = 2'd1,
    ST_BLANK = 2'd2
  } bstate_e;

  // saturating increment used by the blanking offset counter
  function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction
endpackage

// File: rtl/hblk_seq.sv
module hblk_seq
  import hblk_pkg::*;
#(
  parameter int unsigned POS_W = 5,
  parameter int unsigned LEN_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hd,
  input  logic               mask_pol,
  input  logic               pulse_en,
  input  logic               ext_en,
  input  logic               retime_en,
  input  logic [2*POS_W-1:0] pulse_pos,
  input  logic [LEN_W-1:0]   ext_len,
  output logic               gate_raw,
  output logic               lvl_raw,
  output logic               retime_lat,
  output logic               hblk,
  output logic               suspend
);
  localparam int unsigned OFF_W = POS_W + 1;
  localparam logic [7:0]  OFF_MAX = 8'((1 << OFF_W) - 1);

  bstate_e              st;
  logic [LEN_W-1:0]     cnt;
  logic [OFF_W-1:0]     off;
  logic                 mask_lat, pulse_lat;
  logic [2*POS_W-1:0]   pos_lat;
  logic                 start_ev, ext_req, pulse_hit;

  function automatic logic hit(input logic [OFF_W-1:0] o, input logic [2*POS_W-1:0] p);
    return (o == {1'b0, p[POS_W-1:0]}) || (o == {1'b0, p[2*POS_W-1:POS_W]});
  endfunction

  assign start_ev = (st == ST_IDLE) && !hd;
  assign ext_req  = ext_en && (ext_len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      off        <= '0;
      mask_lat   <= 1'b0;
      pulse_lat  <= 1'b0;
      retime_lat <= 1'b0;
      pos_lat    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_ev) begin
          mask_lat   <= mask_pol;
          pulse_lat  <= pulse_en;
          retime_lat <= retime_en;
          pos_lat    <= pulse_pos;
          off        <= '0;
          if (ext_req) begin
            st  <= ST_EXT;
            cnt <= ext_len;
          end else begin
            st <= ST_BLANK;
          end
        end
        ST_EXT: begin
          cnt <= cnt - 1'b1;
          if (cnt == LEN_W'(1)) st <= ST_BLANK;
        end
        ST_BLANK: begin
          if (hd) st <= ST_IDLE;
          else    off <= OFF_W'(sat_inc8(8'(off), OFF_MAX));
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pulse_hit = (st == ST_BLANK) && pulse_lat && hit(off, pos_lat);
  assign gate_raw  = (st != ST_IDLE);
  assign lvl_raw   = pulse_hit ? ~mask_lat : mask_lat;
  assign hblk      = (st == ST_IDLE);
  assign suspend   = (st == ST_EXT);
endmodule

// File: rtl/h1_shaper.sv
module h1_shaper (
  input  logic clk,
  input  logic rst,
  input  logic mask_pol,
  input  logic gate_raw,
  input  logic lvl_raw,
  input  logic retime_lat,
  output logic gate_eff,
  output logic lvl_eff,
  output logic ph
);
  logic gate_q, lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= mask_pol;
      gate_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      ph     <= ~ph;
      gate_q <= gate_raw;
      lvl_q  <= lvl_raw;
    end
  end

  assign gate_eff = retime_lat ? gate_q : gate_raw;
  assign lvl_eff  = retime_lat ? lvl_q  : lvl_raw;
endmodule

// File: rtl/hblk_gen.sv
module hblk_gen #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned LEN_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hd,
  input  logic               mask_pol,
  input  logic               pulse_en,
  input  logic               ext_en,
  input  logic               retime_en,
  input  logic [2*POS_W-1:0] pulse_pos,
  input  logic [LEN_W-1:0]   ext_len,
  output logic               h1,
  output logic               h2,
  output logic               hblk,
  output logic               suspend
);
  logic gate_raw, lvl_raw, retime_lat;
  logic gate_eff, lvl_eff, ph;

  hblk_seq #(.POS_W(POS_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .hd(hd), .mask_pol(mask_pol), .pulse_en(pulse_en),
    .ext_en(ext_en), .retime_en(retime_en), .pulse_pos(pulse_pos), .ext_len(ext_len),
    .gate_raw(gate_raw), .lvl_raw(lvl_raw), .retime_lat(retime_lat),
    .hblk(hblk), .suspend(suspend)
  );

  h1_shaper u_shape (
    .clk(clk), .rst(rst), .mask_pol(mask_pol), .gate_raw(gate_raw),
    .lvl_raw(lvl_raw), .retime_lat(retime_lat),
    .gate_eff(gate_eff), .lvl_eff(lvl_eff), .ph(ph)
  );

  // while reset holds, the shaper gate is low and ph tracks mask_pol
  assign h1 = gate_eff ? lvl_eff : ph;
  assign h2 = ~h1;
endmodule

// File: rtl/hblk_gen_chk.sv
module hblk_gen_chk #(
  parameter int unsigned LEN_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             hd,
  input logic             ext_en,
  input logic [LEN_W-1:0] ext_len,
  input logic             h1,
  input logic             h2,
  input logic             hblk,
  input logic             suspend,
  input logic             gate_eff
);
  logic [LEN_W:0] run;
  logic [LEN_W:0] len_cp;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      len_cp <= '0;
    end else begin
      run <= suspend ? run + 1'b1 : '0;
      if (hblk && !hd) len_cp <= ext_en ? {1'b0, ext_len} : '0;
    end
  end

  assert_h2_inverse_R1: assert property (@(posedge clk) disable iff (rst) h2 == ~h1);

  assert_hblk_rise_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(hblk) && !$past(rst)) |-> $past(hd));

  assert_suspend_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
    suspend |-> !hblk);

  assert_ext_length_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(suspend) && !$past(rst)) |-> (run == len_cp));

  assert_free_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (!gate_eff && $past(!gate_eff) && !$past(rst)) |-> (h1 != $past(h1)));
endmodule

bind hblk_gen hblk_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .hd(hd), .ext_en(ext_en), .ext_len(ext_len),
  .h1(h1), .h2(h2), .hblk(hblk), .suspend(suspend), .gate_eff(gate_eff)
);

// File: tb/hblk_gen_test.sv
module hblk_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hd = 1'b1;
  logic       mask_pol = 1'b0, pulse_en = 1'b0, ext_en = 1'b0, retime_en = 1'b0;
  logic [9:0] pulse_pos = '0;
  logic [8:0] ext_len = '0;
  wire        h1, h2, hblk, suspend;
  int         checks = 0, fails = 0;

  always #4 clk = ~clk;

  hblk_gen uut (
    .clk(clk), .rst(rst), .hd(hd), .mask_pol(mask_pol), .pulse_en(pulse_en),
    .ext_en(ext_en), .retime_en(retime_en), .pulse_pos(pulse_pos), .ext_len(ext_len),
    .h1(h1), .h2(h2), .hblk(hblk), .suspend(suspend)
  );

  typedef struct packed {
    logic       m;
    logic       pe;
    logic       xe;
    logic       rt;
    logic [8:0] len;
    logic [9:0] pos;
    logic [7:0] blen;
  } vec_t;

  // pos 227 -> offsets 3 and 7; pos 320 -> 0 and 10; pos 32 -> 0 and 1
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 10'd227, 8'd12},  // R4 pos ignored
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 10'd0,   8'd6 },  // R4 high mask
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd0, 10'd227, 8'd12},  // R5
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'd0, 10'd320, 8'd14},  // R5
    '{1'b0, 1'b1, 1'b1, 1'b0, 9'd5, 10'd227, 8'd16},  // R6
    '{1'b1, 1'b0, 1'b1, 1'b0, 9'd0, 10'd0,   8'd8 },  // R7 zero length
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'd0, 10'd227, 8'd10},  // R8
    '{1'b1, 1'b1, 1'b1, 1'b1, 9'd3, 10'd32,  8'd9 }   // R5 R6 R8 combined
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic level_at(input vec_t v, input int j);
    if (j < 0) return v.m;
    if (v.pe && (j == int'(v.pos[4:0]) || j == int'(v.pos[9:5]))) return ~v.m;
    return v.m;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int   n, lo, hi, j;
    logic prev;
    n  = (v.xe && v.len != 0) ? int'(v.len) : 0;
    lo = v.rt ? 1 : 0;
    hi = v.rt ? int'(v.blen) : int'(v.blen) - 1;
    @(negedge clk);
    prev = h1;
    mask_pol = v.m; pulse_en = v.pe; ext_en = v.xe; retime_en = v.rt;
    ext_len = v.len; pulse_pos = v.pos; hd = 1'b0;
    for (int k = 0; k < int'(v.blen) + 3; k++) begin
      @(negedge clk);
      chk("R1 h2 inverse", h2, ~h1);
      chk("R6 R7 suspend", suspend, k < n);
      chk("R3 hblk", hblk, !(k < int'(v.blen)));
      if (k >= lo && k <= hi) begin
        j = (v.rt ? k - 1 : k) - n;
        chk("R4 R5 R6 R8 h1 level", h1, level_at(v, j));
      end else if (!(k - 1 >= lo && k - 1 <= hi)) begin
        chk("R10 toggle", h1, ~prev);
      end
      prev = h1;
      if (k == int'(v.blen) - 1) hd = 1'b1;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R2 reset state with both mask levels
    mask_pol = 1'b1;
    idle(3);
    chk("R2 h1 follows mask 1", h1, 1'b1);
    chk("R2 h2 inverse", h2, 1'b0);
    chk("R2 suspend low", suspend, 1'b0);
    chk("R2 hblk high", hblk, 1'b1);
    mask_pol = 1'b0;
    idle(1);
    chk("R2 h1 follows mask 0", h1, 1'b0);
    rst = 1'b0;
    idle(4);

    foreach (VECS[i]) begin
      run_vec(VECS[i]);
      idle(3);
    end

    // R9: controls changed mid-interval leave it untouched
    @(negedge clk);
    mask_pol = 1'b0; pulse_en = 1'b0; ext_en = 1'b0; retime_en = 1'b0;
    pulse_pos = '0; ext_len = '0; hd = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 h1 keeps captured mask", h1, 1'b0);
      chk("R9 no late extension", suspend, 1'b0);
      if (k == 1) begin
        mask_pol = 1'b1; pulse_en = 1'b1; retime_en = 1'b1; ext_en = 1'b1; ext_len = 9'd4;
      end
      if (k == 5) hd = 1'b1;
    end
    @(negedge clk);
    chk("R9 exit on hd high", hblk, 1'b1);
    // next interval uses the new fields: extension of 4
    idle(2);
    hd = 1'b0;
    @(negedge clk);
    chk("R9 new fields take effect", suspend, 1'b1);
    hd = 1'b1;
    idle(8);
    ext_en = 1'b0; ext_len = '0; pulse_en = 1'b0; retime_en = 1'b0;

    // R2: reset during an extension clears it
    @(negedge clk);
    ext_en = 1'b1; ext_len = 9'd20; mask_pol = 1'b1; hd = 1'b0;
    idle(3);
    chk("R2 suspend before reset", suspend, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 suspend cleared", suspend, 1'b0);
    chk("R2 hblk after reset", hblk, 1'b1);
    chk("R2 h1 at mask in reset", h1, 1'b1);
    hd = 1'b1; ext_en = 1'b0; ext_len = '0;
    idle(2);
    rst = 1'b0;
    idle(3);
    chk("R2 idle after reset", hblk, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule